// File: doc/BRIEF.md
# Serial Port Interrupt Request Generator

This block turns the enable bits and status flags of a UART-style serial interface into five separate interrupt request lines for an interrupt controller. The enable bits are held in a small local register that a configuration write loads and that both the hardware reset and a software reset strobe clear. Three requests are plain combinations of an enable and a status flag:

- transmit data empty
- receive data full
- receive with error

When an error is present, the receive-with-error request takes priority over the normal receive request.

Two requests are latched and cleared by an acknowledge from the interrupt controller. The timer request divides the internal baud tick by 16, so the baud generator can act as a periodic interrupt source even when the serial function is unused. The idle-line request fires at most once per idle period. It is raised when a start bit arrives while the line is idle. It is then re-armed only after a complete character has been received.

The timer runs a two-state machine. In `TMR_OFF` the enable is low and the tick counter and request are held clear. `TMR_OFF` moves to `TMR_RUN` when the enable rises. `TMR_RUN` moves back to `TMR_OFF` when the enable falls.

The idle logic runs a four-state machine:

| State | Meaning |
|---|---|
| `IDL_ARMED` | Ready to fire. |
| `IDL_PEND` | Request raised; no character seen since. |
| `IDL_PEND_RCV` | Request raised; a character has completed since. |
| `IDL_SPENT` | Fired; waiting for a character before re-arming. |

The idle transitions are:

- `IDL_ARMED` moves to `IDL_PEND` on a qualified start bit.
- `IDL_PEND` moves to `IDL_PEND_RCV` on a character.
- `IDL_PEND` moves to `IDL_SPENT` on an acknowledge or when the enable drops. If a character arrives in that same cycle, it moves to `IDL_ARMED` instead.
- `IDL_PEND_RCV` moves to `IDL_ARMED` on an acknowledge or when the enable drops.
- `IDL_SPENT` moves to `IDL_ARMED` on a character.

Top module: `serial_irq_gen`

## Requirements
- R1: A cycle with `cfg_we` high loads `cfg_en` into the enable register, effective from the next cycle. The bit positions are: bit 0 timer, bit 1 transmit, bit 2 receive, bit 3 receive-with-error, bit 4 idle. Reset clears all five bits. A `sw_rst` cycle also clears all five bits, and `sw_rst` wins over a simultaneous `cfg_we`.
- R2: While the timer enable is high, the baud ticks are counted from zero, starting at the enable's rise. `tmr_irq` rises in the cycle after every 16th counted tick.
- R3: Once set, `tmr_irq` stays high until a cycle with `tmr_ack`, and is low from the next cycle. A 16th tick in the same cycle as `tmr_ack` keeps it set. A low timer enable clears it from the next cycle.
- R4: The timer request is unaffected by every serial status input (`tdre`, `rdrf`, the error flags, `line_idle`, `start_det`, `char_done`).
- R5: `tx_irq` equals transmit enable AND `tdre`, in the same cycle.
- R6: `rx_exc_irq` equals receive-with-error enable AND (`err_parity` OR `err_frame` OR `err_overrun`), in the same cycle.
- R7: `rx_irq` equals receive enable AND `rdrf` AND NOT `rx_exc_irq`. `rx_irq` and `rx_exc_irq` are never high together.
- R8: When the idle logic is armed, a cycle with `start_det`, `line_idle` and the idle enable all high raises `idle_irq` from the next cycle.
- R9: `idle_irq` stays high until `idle_ack` or a low idle enable, and then falls in the next cycle. After that it cannot rise again until a `char_done` has been seen, either during or after the pending period.
- R10: The idle logic is armed after reset, so the first qualified start bit raises `idle_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| sw_rst | input | 1 | Software reset strobe; clears the enables |
| cfg_we | input | 1 | Enable register load strobe |
| cfg_en | input | 5 | Enable bits to load (timer, tx, rx, rx-error, idle at bits 0 to 4) |
| tdre | input | 1 | Transmit data register empty flag |
| rdrf | input | 1 | Receive data register full flag |
| err_parity | input | 1 | Parity error flag |
| err_frame | input | 1 | Framing error flag |
| err_overrun | input | 1 | Overrun flag |
| line_idle | input | 1 | Receive line idle flag |
| start_det | input | 1 | Valid start bit detected strobe |
| char_done | input | 1 | Complete character received strobe |
| baud_tick | input | 1 | Internal serial clock tick |
| tmr_ack | input | 1 | Timer interrupt acknowledge |
| idle_ack | input | 1 | Idle interrupt acknowledge |
| tmr_irq | output | 1 | Timer interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_exc_irq | output | 1 | Receive-with-error interrupt request |
| idle_irq | output | 1 | Idle line interrupt request |

## Verification
A wrong tick count shows as `tmr_irq` rising one or more cycles early or late relative to the 16th tick. This is visible on the first period after enabling, because the count restarts from zero. A corrupted idle state appears on `idle_irq` in one of two ways: as a second request within one idle period, or as a request that never rises after a character re-armed it. Either shows within a cycle of the next qualified start bit. Enable register faults show on the very next cycle as a combinational request that disagrees with its status flag. The reference model is compared against all five request lines every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int NUM_SRC = 5;
    localparam int EN_TMR  = 0;
    localparam int EN_TX   = 1;
    localparam int EN_RX   = 2;
    localparam int EN_RXE  = 3;
    localparam int EN_IDLE = 4;

    typedef enum logic [0:0] {
        TMR_OFF = 1'b0,
        TMR_RUN = 1'b1
    } tmr_state_t;

    typedef enum logic [1:0] {
        IDL_ARMED    = 2'd0,
        IDL_PEND     = 2'd1,
        IDL_PEND_RCV = 2'd2,
        IDL_SPENT    = 2'd3
    } idl_state_t;
endpackage

// File: rtl/sirq_cfg.sv
module sirq_cfg
    import sirq_pkg::*;
#(
    parameter int W = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    logic [W-1:0] en_q;
    logic [W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (sw_rst) begin
            en_d = '0;
        end else if (we) begin
            en_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;

    // R1: software reset empties the enable register
    p_swrst_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (en_q == '0));

    // R1: a write without software reset lands next cycle
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sw_rst) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/sirq_timer.sv
module sirq_timer
    import sirq_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic ack,
    output logic req
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    tmr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          req_q, req_d;
    logic          wrap;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_OFF: if (en)  state_d = TMR_RUN;
            TMR_RUN: if (!en) state_d = TMR_OFF;
        endcase
    end

    // counter and request flag
    always_comb begin
        cnt_d = cnt_q;
        req_d = req_q;
        wrap  = 1'b0;
        if (!en) begin
            cnt_d = '0;
            req_d = 1'b0;
        end else begin
            if (tick) begin
                if (cnt_q == LAST) begin
                    cnt_d = '0;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            if (wrap) begin
                req_d = 1'b1;
            end else if (ack) begin
                req_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_OFF;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            req_q   <= req_d;
        end
    end

    assign req = req_q;

    // R2: counting restarts from zero when the enable rises
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_OFF && en && !tick) |=> (cnt_q == '0 && !req_q));

    // R2: the last tick of a period raises the request
    p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && cnt_q == LAST) |=> req_q);

    // R3: an acknowledge without a coincident wrap clears it
    p_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ack && !(tick && cnt_q == LAST)) |=> !req_q);

    // R3: request held until acknowledged
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && en && !ack) |=> req_q);

    // R3: disabled timer drops its request
    p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req_q);
endmodule

// File: rtl/sirq_idle.sv
module sirq_idle
    import sirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_idle,
    input  logic start_det,
    input  logic char_done,
    input  logic ack,
    output logic req
);
    idl_state_t state_q, state_d;
    logic       qual_start;
    logic       release_req;

    assign qual_start  = start_det && line_idle && en;
    assign release_req = ack || !en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDL_ARMED: begin
                if (qual_start) state_d = IDL_PEND;
            end
            IDL_PEND: begin
                if (release_req) begin
                    state_d = char_done ? IDL_ARMED : IDL_SPENT;
                end else if (char_done) begin
                    state_d = IDL_PEND_RCV;
                end
            end
            IDL_PEND_RCV: begin
                if (release_req) state_d = IDL_ARMED;
            end
            IDL_SPENT: begin
                if (char_done) state_d = IDL_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDL_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IDL_PEND, IDL_PEND_RCV: req = 1'b1;
            default:                req = 1'b0;
        endcase
    end

    // R8: armed logic fires on a qualified start bit
    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDL_ARMED && qual_start) |=> req);

    // R9: request held until acknowledged or disabled
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && en && !ack) |=> req);

    // R9: no second request before a character arrives
    p_norefire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDL_SPENT && !char_done) |=> !req);
endmodule

// File: rtl/sirq_rx_arb.sv
module sirq_rx_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic en_rx,
    input  logic en_rxe,
    input  logic rdrf,
    input  logic err_parity,
    input  logic err_frame,
    input  logic err_overrun,
    output logic rx_req,
    output logic rx_exc_req
);
    logic any_err;

    always_comb begin
        any_err    = err_parity | err_frame | err_overrun;
        rx_exc_req = en_rxe & any_err;
        rx_req     = en_rx & rdrf & ~rx_exc_req;
    end

    // R7: normal and error receive requests are exclusive
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_req && rx_exc_req));

    // R6: an enabled error always yields the error request
    p_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rxe && (err_parity || err_frame || err_overrun)) |-> rx_exc_req);
endmodule

// File: rtl/serial_irq_gen.sv
module serial_irq_gen
    import sirq_pkg::*;
#(
    parameter int TICK_DIV = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst,
    input  logic               cfg_we,
    input  logic [NUM_SRC-1:0] cfg_en,
    input  logic               tdre,
    input  logic               rdrf,
    input  logic               err_parity,
    input  logic               err_frame,
    input  logic               err_overrun,
    input  logic               line_idle,
    input  logic               start_det,
    input  logic               char_done,
    input  logic               baud_tick,
    input  logic               tmr_ack,
    input  logic               idle_ack,
    output logic               tmr_irq,
    output logic               tx_irq,
    output logic               rx_irq,
    output logic               rx_exc_irq,
    output logic               idle_irq
);
    logic [NUM_SRC-1:0] en;

    sirq_cfg #(.W(NUM_SRC)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_rst(sw_rst),
        .we    (cfg_we),
        .wdata (cfg_en),
        .en    (en)
    );

    sirq_timer #(.DIV(TICK_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en[EN_TMR]),
        .tick (baud_tick),
        .ack  (tmr_ack),
        .req  (tmr_irq)
    );

    sirq_idle u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en[EN_IDLE]),
        .line_idle(line_idle),
        .start_det(start_det),
        .char_done(char_done),
        .ack      (idle_ack),
        .req      (idle_irq)
    );

    sirq_rx_arb u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_rx      (en[EN_RX]),
        .en_rxe     (en[EN_RXE]),
        .rdrf       (rdrf),
        .err_parity (err_parity),
        .err_frame  (err_frame),
        .err_overrun(err_overrun),
        .rx_req     (rx_irq),
        .rx_exc_req (rx_exc_irq)
    );

    assign tx_irq = en[EN_TX] & tdre;

    // R5: transmit request needs an empty transmit register
    p_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tdre);
endmodule

// File: tb/sim_serial_irq_gen.sv
module sim_serial_irq_gen;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0, sw_rst = 1'b0, cfg_we = 1'b0;
    logic [4:0] cfg_en = '0;
    logic       tdre = 0, rdrf = 0, err_parity = 0, err_frame = 0, err_overrun = 0;
    logic       line_idle = 0, start_det = 0, char_done = 0, baud_tick = 0;
    logic       tmr_ack = 0, idle_ack = 0;
    logic       tmr_irq, tx_irq, rx_irq, rx_exc_irq, idle_irq;

    serial_irq_gen u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_we(cfg_we), .cfg_en(cfg_en),
        .tdre(tdre), .rdrf(rdrf), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .line_idle(line_idle), .start_det(start_det),
        .char_done(char_done), .baud_tick(baud_tick), .tmr_ack(tmr_ack),
        .idle_ack(idle_ack), .tmr_irq(tmr_irq), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .rx_exc_irq(rx_exc_irq), .idle_irq(idle_irq)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit [4:0] m_en;
    int       m_ticks;
    bit       m_tflag, m_armed, m_pend, m_seen_char;

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_en = '0; m_ticks = 0; m_tflag = 0;
        m_armed = 1; m_pend = 0; m_seen_char = 0;
    endtask

    task automatic model_clock();
        bit [4:0] old_en;
        bit       fire;
        if (!rst_n) begin
            model_reset();
            return;
        end
        old_en = m_en;
        if (sw_rst)      m_en = '0;
        else if (cfg_we) m_en = cfg_en;
        fire = 0;
        if (!old_en[0]) begin
            m_ticks = 0; m_tflag = 0;
        end else begin
            if (baud_tick) begin
                m_ticks++;
                if (m_ticks == 16) begin m_ticks = 0; fire = 1; end
            end
            if (fire)         m_tflag = 1;
            else if (tmr_ack) m_tflag = 0;
        end
        if (m_pend) begin
            if (idle_ack || !old_en[4]) begin
                m_armed = m_seen_char || char_done;
                m_pend = 0; m_seen_char = 0;
            end else if (char_done) begin
                m_seen_char = 1;
            end
        end else if (m_armed) begin
            if (start_det && line_idle && old_en[4]) begin
                m_pend = 1; m_armed = 0; m_seen_char = 0;
            end
        end else if (char_done) begin
            m_armed = 1;
        end
    endtask

    task automatic compare();
        bit exc;
        exc = m_en[3] && (err_parity || err_frame || err_overrun);
        chk("R2/R3", "tmr_irq", tmr_irq, m_tflag);
        chk("R5", "tx_irq", tx_irq, m_en[1] && tdre);
        chk("R6", "rx_exc_irq", rx_exc_irq, exc);
        chk("R7", "rx_irq", rx_irq, m_en[2] && rdrf && !exc);
        chk("R8/R9", "idle_irq", idle_irq, m_pend);
    endtask

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            model_clock();
            compare();
        end
    endtask

    task automatic load(logic [4:0] v);
        cfg_we = 1; cfg_en = v; step(); cfg_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        step(2);
        chk("R1", "reset tx_irq", tx_irq, 1'b0);
        rst_n = 1;
        step();

        // R1, R5: transmit enable load and tdre patterns
        load(5'b00010);
        tdre = 1; step(); tdre = 0; step();
        tdre = 1; step(2);
        load(5'b00000); step(); tdre = 0;

        // R6, R7: receive priority
        load(5'b01100);
        rdrf = 1; step();
        err_parity = 1; step(); err_parity = 0;
        err_frame = 1; step(); err_frame = 0;
        err_overrun = 1; step();
        load(5'b00100); step();
        chk("R7", "rx_irq with error but error enable off", rx_irq, 1'b1);
        err_overrun = 0; rdrf = 0; step();

        // R2, R3, R4: timer with noisy status inputs
        load(5'b00001);
        for (int i = 0; i < 60; i++) begin
            baud_tick = (i % 3 != 2);
            tdre = i[0]; rdrf = i[1]; err_frame = i[2]; line_idle = i[3];
            char_done = i[1]; start_det = i[2];
            step();
            chk("R4", "tmr_irq under status noise", tmr_irq, m_tflag);
        end
        baud_tick = 0; tdre = 0; rdrf = 0; err_frame = 0;
        line_idle = 0; char_done = 0; start_det = 0;
        tmr_ack = 1; step(); tmr_ack = 0; step();
        for (int i = 0; i < 120; i++) begin
            baud_tick = 1;
            tmr_ack = (i % 7 == 0);
            step();
        end
        baud_tick = 0; tmr_ack = 0;
        load(5'b00000); step(2);
        load(5'b00001);
        for (int i = 0; i < 40; i++) begin
            baud_tick = 1; step();
        end
        baud_tick = 0;
        load(5'b00000); step();

        // R8, R9, R10: idle line request
        load(5'b10000);
        line_idle = 1; start_det = 1; step(); start_det = 0;
        chk("R10", "first idle after reset", idle_irq, 1'b1);
        step(3);
        idle_ack = 1; step(); idle_ack = 0;
        start_det = 1; step(); start_det = 0;
        chk("R9", "no refire before character", idle_irq, 1'b0);
        char_done = 1; step(); char_done = 0;
        start_det = 1; step(); start_det = 0;
        chk("R9", "refire after character", idle_irq, 1'b1);
        char_done = 1; step(); char_done = 0; step();
        idle_ack = 1; step(); idle_ack = 0;
        start_det = 1; step(); start_det = 0;
        chk("R9", "char during pending rearms", idle_irq, 1'b1);
        load(5'b00000); step();
        load(5'b10000);
        line_idle = 0; start_det = 1; step(); start_det = 0;
        chk("R8", "start without idle line", idle_irq, 1'b0);
        char_done = 1; step(); char_done = 0;
        line_idle = 1; start_det = 1; step(); start_det = 0;
        chk("R8", "qualified start", idle_irq, 1'b1);

        // R1: software reset beats a simultaneous write
        tdre = 1; rdrf = 1; err_parity = 1;
        load(5'b11111); step();
        sw_rst = 1; cfg_we = 1; cfg_en = 5'b11111; step();
        sw_rst = 0; cfg_we = 0;
        chk("R1", "tx_irq after sw reset", tx_irq, 1'b0);
        chk("R1", "rx_exc_irq after sw reset", rx_exc_irq, 1'b0);
        step(2);

        // hardware reset mid-run
        load(5'b11111);
        rst_n = 0; step(); rst_n = 1; step();
        chk("R1", "tx_irq after hw reset", tx_irq, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule